// File: doc/BRIEF.md
# HDLC Receive Deframer

This block sits behind a line receiver and accepts one serial bit each time the bit strobe is high. It searches for the frame delimiter, removes the zeros that a transmitter inserted after runs of five ones, and packs the remaining bits into bytes, least significant bit first. Bytes come out on a byte-wide valid interface. Start-of-frame and end-of-frame markers ride on the first and last beats, and the last beat also carries a good/bad verdict.

The two bytes just before the closing delimiter are the frame check sequence. They are held back and never delivered as payload. A CRC-16 residue test over the whole received body, together with a minimum length test and a byte alignment test, decides the verdict. A run of seven ones inside a frame cancels that frame with an abort indication, and a long run of ones raises an idle level. Two frames may share one delimiter, and repeated delimiters with nothing between them are silently absorbed.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A 0 bit that arrives directly after five consecutive 1 bits is discarded and never becomes part of a byte.
- R2: The bit pattern 0,1,1,1,1,1,1,0 (six ones between zeros) opens a frame and also closes the open one. A single delimiter may close one frame and open the next. Delimiters with no complete byte between them produce no output.
- R3: A frame of N complete bytes, with N of at least 3, yields exactly N-2 beats carrying the first N-2 bytes in order. The last two bytes are never delivered. The first beat has sof_o=1 and the last beat has eof_o=1.
- R4: frame_good_o is 1 on the end beat only if the CRC (reflected polynomial 0x8408, preset 0xFFFF, bits processed LSB first) run over all complete bytes, including the transmitted complement of the CRC sent low byte first, leaves the residue 0xF0B8. A corrupted check sequence gives frame_good_o=0.
- R5: A frame with fewer than 4 complete bytes, or whose bit count between delimiters is not a multiple of 8, ends with frame_good_o=0. A 1-, 2- or 3-byte frame gives a single beat with sof_o=1 and eof_o=1. Its byte_o is the first byte when 3 bytes were received and 0 otherwise.
- R6: A seventh consecutive 1 inside a frame that holds at least one complete byte ends that frame with one beat where eof_o=1, abort_o=1, frame_good_o=0 and byte_o=0. The block then ignores all bits until the next delimiter. Seven ones with no complete byte received produce no beat.
- R7: idle_o is 1 while the most recent 15 or more strobed bits were all 1, and returns to 0 on the next strobed 0.
- R8: Every output changes on the clock edge that samples the causing strobe. sof_o, eof_o, abort_o, frame_good_o and byte_valid_o are one-clock pulses.
- R9: While reset is asserted and after its release, all outputs are 0.
- R10: bit_i is ignored in any cycle where bit_en_i is 0.
- R11: Bits received before the first delimiter after reset produce no beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit strobe; bit_i is taken when high |
| bit_i | input | 1 | Serial line bit |
| byte_valid_o | output | 1 | Beat valid |
| byte_o | output | 8 | Payload byte of the beat |
| sof_o | output | 1 | Beat is the first of a frame |
| eof_o | output | 1 | Beat is the last of a frame |
| frame_good_o | output | 1 | Frame verdict, meaningful with eof_o |
| abort_o | output | 1 | Frame ended by an abort run |
| idle_o | output | 1 | Long run of ones seen on the line |

## Verification
Every result is due one clock after the edge that samples its strobe. A payload beat follows the strobe that completes the fourth and later bytes, and the end beat follows the final 0 of the closing delimiter or the seventh one of an abort. The bench drives a strobe for one clock, leaves it low for one clock with bit_i inverted, and records beats at the falling edge between those two rising edges. One test checks directly that the end beat is absent before the closing edge, present one clock later, and gone one clock after that. The idle level is read just after the edge of the 14th, 15th and 16th ones, and after the following 0.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef struct packed {
    logic push;     // bit is payload
    logic discard;  // stuffed zero
    logic flag;     // delimiter complete
    logic abort;    // seventh one
  } bit_evt_t;

  function automatic logic [15:0] crc16_byte(input logic [15:0] crc,
                                             input logic [7:0]  data,
                                             input logic [15:0] poly);
    logic [15:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ data[i]) c = (c >> 1) ^ poly;
      else                c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/hdlc_rx_ones_tracker.sv
module hdlc_rx_ones_tracker
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_ONES = 15
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     bit_i,
  output bit_evt_t evt_o,
  output logic     idle_o
);

  localparam int CW = $clog2(IDLE_ONES + 1);
  localparam logic [CW-1:0] STUFF_RUN = CW'(5);
  localparam logic [CW-1:0] FLAG_RUN  = CW'(6);
  localparam logic [CW-1:0] RUN_MAX   = CW'(IDLE_ONES);

  logic [CW-1:0] ones_q;

  always_comb begin
    evt_o      = '0;
    evt_o.push = (ones_q < STUFF_RUN);
    if (bit_i) begin
      evt_o.abort = (ones_q == FLAG_RUN);
    end else begin
      evt_o.discard = (ones_q == STUFF_RUN);
      evt_o.flag    = (ones_q == FLAG_RUN);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
    end else if (en_i) begin
      if (!bit_i)                ones_q <= '0;
      else if (ones_q != RUN_MAX) ones_q <= ones_q + 1'b1;
    end
  end

  assign idle_o = (ones_q == RUN_MAX);

  a_r7_idle_needs_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> $past(en_i && bit_i));

  a_r7_idle_drops_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bit_i) |=> !idle_o);

endmodule

// File: rtl/hdlc_rx_bit_packer.sv
module hdlc_rx_bit_packer #(
  parameter int W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 push_i,
  input  logic                 bit_i,
  output logic                 byte_done_o,
  output logic [W-1:0]         byte_o,
  output logic [$clog2(W)-1:0] phase_o
);

  localparam int PW = $clog2(W);
  localparam logic [PW-1:0] LAST_PH = PW'(W - 1);

  logic [W-1:0]  sr_q;
  logic [PW-1:0] ph_q;

  // LSB arrives first: shift right, new bit at the top
  assign byte_o      = {bit_i, sr_q[W-1:1]};
  assign byte_done_o = push_i && (ph_q == LAST_PH);
  assign phase_o     = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      ph_q <= '0;
    end else if (clr_i) begin
      sr_q <= '0;
      ph_q <= '0;
    end else if (push_i) begin
      sr_q <= byte_o;
      ph_q <= ph_q + 1'b1;
    end
  end

  a_r5_phase_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |=> (phase_o == '0));

endmodule

// File: rtl/hdlc_rx_crc16.sv
module hdlc_rx_crc16
  import hdlc_rx_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h8408,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);

  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT;
    else if (clr_i)  crc_q <= INIT;
    else if (en_i)   crc_q <= crc16_byte(crc_q, byte_i, POLY);
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/hdlc_rx_holdline.sv
module hdlc_rx_holdline #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] oldest_o,
  output logic         full_o
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [CW-1:0] cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [W-1:0] q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (shift_i) q <= din_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (shift_i) q <= g_stage[g-1].q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (shift_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign oldest_o = g_stage[DEPTH-1].q;
  assign full_o   = (cnt_q == CNT_MAX);

  a_r3_fill_needs_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(shift_i));

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int          IDLE_ONES = 15,
  parameter int          MIN_BYTES = 4,
  parameter int          FCS_BYTES = 2,
  parameter logic [15:0] CRC_POLY  = 16'h8408,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  parameter logic [15:0] CRC_GOOD  = 16'hF0B8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       bit_i,
  output logic       byte_valid_o,
  output logic [7:0] byte_o,
  output logic       sof_o,
  output logic       eof_o,
  output logic       frame_good_o,
  output logic       abort_o,
  output logic       idle_o
);

  localparam int HOLD = FCS_BYTES + 1;  // extra stage lets eof ride on last payload byte
  localparam int BCW  = $clog2(MIN_BYTES + 1);
  localparam logic [BCW-1:0] BCNT_MAX = BCW'(MIN_BYTES);
  localparam logic [2:0]     ALIGN_PH = 3'(6);  // flag bits that reach the packer

  bit_evt_t    evt;
  logic        open_q, sof_sent_q;
  logic [BCW-1:0] bcnt_q;
  logic        push_bit, restart, byte_done, hold_full;
  logic [7:0]  asm_byte, hold_oldest;
  logic [2:0]  phase;
  logic [15:0] crc;
  logic        has_bytes, frame_ok;

  hdlc_rx_ones_tracker #(.IDLE_ONES(IDLE_ONES)) u_ones (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (bit_en_i),
    .bit_i  (bit_i),
    .evt_o  (evt),
    .idle_o (idle_o)
  );

  assign push_bit = bit_en_i && evt.push && open_q;
  assign restart  = bit_en_i && evt.flag;

  hdlc_rx_bit_packer #(.W(8)) u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (restart),
    .push_i      (push_bit),
    .bit_i       (bit_i),
    .byte_done_o (byte_done),
    .byte_o      (asm_byte),
    .phase_o     (phase)
  );

  hdlc_rx_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .en_i   (byte_done),
    .byte_i (asm_byte),
    .crc_o  (crc)
  );

  hdlc_rx_holdline #(.W(8), .DEPTH(HOLD)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (restart),
    .shift_i  (byte_done),
    .din_i    (asm_byte),
    .oldest_o (hold_oldest),
    .full_o   (hold_full)
  );

  assign has_bytes = (bcnt_q != '0);
  assign frame_ok  = (bcnt_q == BCNT_MAX) && (phase == ALIGN_PH) && (crc == CRC_GOOD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q       <= 1'b0;
      sof_sent_q   <= 1'b0;
      bcnt_q       <= '0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
      sof_o        <= 1'b0;
      eof_o        <= 1'b0;
      frame_good_o <= 1'b0;
      abort_o      <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
      sof_o        <= 1'b0;
      eof_o        <= 1'b0;
      frame_good_o <= 1'b0;
      abort_o      <= 1'b0;
      if (bit_en_i) begin
        if (evt.flag) begin
          if (open_q && has_bytes) begin
            byte_valid_o <= 1'b1;
            eof_o        <= 1'b1;
            sof_o        <= !sof_sent_q;
            byte_o       <= hold_full ? hold_oldest : '0;
            frame_good_o <= frame_ok;
          end
          open_q     <= 1'b1;
          sof_sent_q <= 1'b0;
          bcnt_q     <= '0;
        end else if (evt.abort) begin
          if (open_q && has_bytes) begin
            byte_valid_o <= 1'b1;
            eof_o        <= 1'b1;
            abort_o      <= 1'b1;
            sof_o        <= !sof_sent_q;
          end
          open_q <= 1'b0;
        end else if (byte_done) begin
          if (bcnt_q != BCNT_MAX) bcnt_q <= bcnt_q + 1'b1;
          if (hold_full) begin
            byte_valid_o <= 1'b1;
            byte_o       <= hold_oldest;
            sof_o        <= !sof_sent_q;
            sof_sent_q   <= 1'b1;
          end
        end
      end
    end
  end

  // assertion-only tracking of packet boundaries at the output
  logic pkt_open_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pkt_open_q <= 1'b0;
    else if (byte_valid_o) pkt_open_q <= !eof_o;
  end

  a_r3_sof_outside_pkt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && sof_o) |-> !pkt_open_q);

  a_r3_cont_inside_pkt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !sof_o) |-> pkt_open_q);

  a_r2_end_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && eof_o && !abort_o) |-> $past(bit_en_i && !bit_i));

  a_r6_abort_on_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(bit_en_i && bit_i));

  a_r6_abort_is_bad_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (byte_valid_o && eof_o && !frame_good_o && byte_o == 8'h00));

  a_r4_verdict_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_good_o |-> (byte_valid_o && eof_o));

  a_r10_beat_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(bit_en_i));

  a_r1_stuffed_zero_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && evt.discard) |=> !byte_valid_o);

endmodule

// File: tb/hdlc_rx_deframer_bench.sv
module hdlc_rx_deframer_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic bit_in = 1'b0;
  logic       byte_valid, sof, eof, good, abrt, idle;
  logic [7:0] byte_out;

  always #4 clk = ~clk;  // 125 MHz

  hdlc_rx_deframer u_hdlc_rx_deframer (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bit_en_i     (bit_en),
    .bit_i        (bit_in),
    .byte_valid_o (byte_valid),
    .byte_o       (byte_out),
    .sof_o        (sof),
    .eof_o        (eof),
    .frame_good_o (good),
    .abort_o      (abrt),
    .idle_o       (idle)
  );

  int n_chk = 0;
  int n_fail = 0;
  int tx_ones = 0;
  bit done = 0;
  logic [7:0] fbuf [16];
  logic [7:0] cap_b [64];
  bit cap_sof [64], cap_eof [64], cap_good [64], cap_ab [64];
  int cap_n = 0;

  always @(negedge clk) begin
    if (rst_n && byte_valid && cap_n < 64) begin
      cap_b[cap_n]    = byte_out;
      cap_sof[cap_n]  = sof;
      cap_eof[cap_n]  = eof;
      cap_good[cap_n] = good;
      cap_ab[cap_n]   = abrt;
      cap_n++;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic send_bit(input bit b);
    @(posedge clk); #1;
    bit_en = 1'b1; bit_in = b;
    @(posedge clk); #1;
    bit_en = 1'b0; bit_in = ~b;  // noise while strobe low
  endtask

  task automatic send_dbit(input bit b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_bit(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_dbyte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) send_dbit(d[i]);
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic noise(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; bit_in = 1'b1;
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        bit fb = c[0] ^ fbuf[k][i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return c;
  endfunction

  // fcs_mode: 0 none, 1 good, 2 corrupted
  task automatic send_body(input int n, input int fcs_mode, input int extra, input int noise_at);
    logic [15:0] fcs;
    fcs = ~ref_crc(n);
    if (fcs_mode == 2) fcs = fcs ^ 16'h0001;
    for (int i = 0; i < n; i++) begin
      if (i == noise_at) noise(20);
      send_dbyte(fbuf[i]);
    end
    if (fcs_mode != 0) begin
      send_dbyte(fcs[7:0]);
      send_dbyte(fcs[15:8]);
    end
    for (int i = 0; i < extra; i++) send_dbit(1'b0);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_frame(input int first, input int n, input bit exp_good, input string tag);
    check(cap_n == first + n, {tag, " beat count"}, cap_n, first + n);
    for (int i = 0; i < n; i++) begin
      if (first + i < cap_n) begin
        check(cap_b[first+i] == fbuf[i], {tag, " byte"}, cap_b[first+i], fbuf[i]);
        check(cap_sof[first+i] == (i == 0), {tag, " sof"}, cap_sof[first+i], (i == 0));
        check(cap_eof[first+i] == (i == n - 1), {tag, " eof"}, cap_eof[first+i], (i == n - 1));
      end
    end
    if (cap_n == first + n && n > 0) begin
      check(cap_good[cap_n-1] == exp_good, {tag, " verdict"}, cap_good[cap_n-1], exp_good);
      check(cap_ab[cap_n-1] == 1'b0, {tag, " no abort"}, cap_ab[cap_n-1], 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check({byte_valid, sof, eof, good, abrt, idle} == 6'b0, "R9 outputs in reset", {byte_valid, sof, eof, good, abrt, idle}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({byte_valid, sof, eof, good, abrt, idle, byte_out} == '0, "R9 outputs after reset", byte_out, 0);
  endtask

  task automatic t_hunt();
    send_dbyte(8'h55); send_dbyte(8'h0F); send_dbyte(8'hF3);
    settle();
    check(cap_n == 0, "R11 no beats before first delimiter", cap_n, 0);
  endtask

  task automatic t_good_and_timing();
    int base = cap_n;
    fbuf[0] = 8'h7E; fbuf[1] = 8'hFF; fbuf[2] = 8'h3F; fbuf[3] = 8'hA5; fbuf[4] = 8'h00;
    send_flag();
    send_body(5, 1, 0, -1);
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    @(posedge clk); #1; bit_en = 1'b1; bit_in = 1'b0;
    @(negedge clk);
    check(eof == 1'b0, "R8 end beat not before closing edge", eof, 0);
    @(posedge clk); #1; bit_en = 1'b0; bit_in = 1'b1;
    @(negedge clk);
    check(eof == 1'b1 && byte_valid == 1'b1, "R8 end beat one clock after closing strobe", eof, 1);
    @(negedge clk);
    check(eof == 1'b0 && byte_valid == 1'b0, "R8 end beat lasts one clock", eof, 0);
    tx_ones = 0;
    expect_frame(base, 5, 1'b1, "R1 R3 R4 stuffed good frame");
  endtask

  task automatic t_shared_flag();
    int base = cap_n;
    fbuf[0] = 8'h01; fbuf[1] = 8'h03; fbuf[2] = 8'hC0; fbuf[3] = 8'hFE;
    send_body(4, 1, 0, -1);
    send_flag();
    settle();
    expect_frame(base, 4, 1'b1, "R2 frame closed by shared delimiter");
    base = cap_n;
    fbuf[0] = 8'h99; fbuf[1] = 8'h1F; fbuf[2] = 8'hF8;
    send_body(3, 1, 0, -1);
    send_flag(); send_flag(); send_flag();
    settle();
    expect_frame(base, 3, 1'b1, "R2 frame opened by shared delimiter");
    check(cap_n == base + 3, "R2 empty delimiters silent", cap_n, base + 3);
  endtask

  task automatic t_strobe_gating();
    int base = cap_n;
    fbuf[0] = 8'h10; fbuf[1] = 8'h20; fbuf[2] = 8'h30; fbuf[3] = 8'h40; fbuf[4] = 8'h50;
    send_body(5, 1, 0, 2);
    send_flag();
    settle();
    expect_frame(base, 5, 1'b1, "R10 ones with strobe low ignored");
  endtask

  task automatic t_bad_crc();
    int base = cap_n;
    fbuf[0] = 8'hDE; fbuf[1] = 8'hAD; fbuf[2] = 8'hBE; fbuf[3] = 8'hEF;
    send_body(4, 2, 0, -1);
    send_flag();
    settle();
    expect_frame(base, 4, 1'b0, "R4 corrupted check sequence");
  endtask

  task automatic t_short();
    int base = cap_n;
    fbuf[0] = 8'h42;
    send_body(1, 1, 0, -1);
    send_flag();
    settle();
    expect_frame(base, 1, 1'b0, "R5 three-byte frame");
    base = cap_n;
    fbuf[0] = 8'h6C;
    send_body(1, 0, 0, -1);
    send_flag();
    settle();
    check(cap_n == base + 1, "R5 one-byte frame beat count", cap_n, base + 1);
    if (cap_n == base + 1) begin
      check(cap_sof[base] && cap_eof[base] && !cap_good[base], "R5 one-byte frame marks", {cap_sof[base], cap_eof[base], cap_good[base]}, 3'b110);
      check(cap_b[base] == 8'h00, "R5 one-byte frame byte", cap_b[base], 0);
    end
  endtask

  task automatic t_misaligned();
    int base = cap_n;
    fbuf[0] = 8'h11; fbuf[1] = 8'h22; fbuf[2] = 8'h44; fbuf[3] = 8'h88;
    send_body(4, 1, 1, -1);
    send_flag();
    settle();
    expect_frame(base, 4, 1'b0, "R5 stray bit before delimiter");
  endtask

  task automatic t_abort();
    int base = cap_n;
    fbuf[0] = 8'h11; fbuf[1] = 8'h22; fbuf[2] = 8'h33; fbuf[3] = 8'h44; fbuf[4] = 8'h55;
    send_body(5, 0, 0, -1);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    send_bit(1'b0);
    tx_ones = 0;
    settle();
    check(cap_n == base + 3, "R6 beats up to abort", cap_n, base + 3);
    if (cap_n == base + 3) begin
      check(cap_b[base] == 8'h11 && cap_sof[base], "R6 first beat before abort", cap_b[base], 8'h11);
      check(cap_b[base+1] == 8'h22 && !cap_eof[base+1], "R6 second beat before abort", cap_b[base+1], 8'h22);
      check(cap_ab[base+2] && cap_eof[base+2] && !cap_good[base+2] && !cap_sof[base+2],
            "R6 abort end beat marks", {cap_ab[base+2], cap_eof[base+2], cap_good[base+2], cap_sof[base+2]}, 4'b1100);
      check(cap_b[base+2] == 8'h00, "R6 abort beat byte", cap_b[base+2], 0);
    end
    send_dbyte(8'h55); send_dbyte(8'h0A); send_dbyte(8'h3C); send_dbyte(8'h77);
    settle();
    check(cap_n == base + 3, "R6 bits ignored after abort", cap_n, base + 3);
    base = cap_n;
    fbuf[0] = 8'hC3; fbuf[1] = 8'h5A; fbuf[2] = 8'h0F;
    send_flag();
    send_body(3, 1, 0, -1);
    send_flag();
    settle();
    expect_frame(base, 3, 1'b1, "R6 recovery after abort");
  endtask

  task automatic t_idle();
    int base = cap_n;
    for (int i = 1; i <= 16; i++) begin
      send_bit(1'b1);
      if (i == 14) check(idle == 1'b0, "R7 idle low after 14 ones", idle, 0);
      if (i == 15) check(idle == 1'b1, "R7 idle high after 15 ones", idle, 1);
      if (i == 16) check(idle == 1'b1, "R7 idle held after 16 ones", idle, 1);
    end
    send_bit(1'b0);
    check(idle == 1'b0, "R7 idle drops on zero", idle, 0);
    tx_ones = 0;
    settle();
    check(cap_n == base, "R6 no beat for ones without bytes", cap_n, base);
  endtask

  initial begin
    t_reset();
    t_hunt();
    t_good_and_timing();
    t_shared_flag();
    t_strobe_gating();
    t_bad_crc();
    t_short();
    t_misaligned();
    t_abort();
    t_idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule